// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of page translations. Each entry holds a virtual page number, the address-space tag of the process that owns it, a physical frame number and a set of permission bits. A lookup presents a page number, an address-space tag and a read/write flag. It gets a hit, a miss or a permission fault back combinationally in the same cycle, together with the frame number and permissions of the matching entry.

On a miss, an external table walker fetches the mapping and installs it through the fill port. The new entry can be seen from the next cycle. The fill picks its slot in this order:
- an entry that already holds the same page and tag;
- otherwise the lowest free slot;
- otherwise a rotating eviction pointer.

An invalidation port removes entries in one of three ways:
- every entry, for a context switch without tags;
- every entry of one address space;
- one page of one address space, for a remote shootdown.

Because entries carry their owner's tag, switching context needs no flush.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss.
- R2: A lookup hits only an entry that is valid and matches both the page number and the address-space tag. The frame number and permissions appear on the outputs in the same cycle as the request.
- R3: While a lookup is requested, exactly one of hit, miss and permission fault is high. While no lookup is requested, all three are low.
- R4: Permission bit 0 is write-allowed, bit 1 is execute-allowed and bit 2 is user-accessible. A write lookup that matches an entry whose bit 0 is clear reports a permission fault and no hit. A read lookup of the same entry hits.
- R5: A fill writes page, tag, frame and permissions into an entry, and the entry is visible to lookups from the next cycle.
- R6: A fill whose page number and tag match a valid entry overwrites that entry. It does not take a second slot.
- R7: A fill with no matching entry takes the lowest-numbered invalid slot. When all slots are valid, it takes the slot named by an eviction pointer. The pointer starts at 0 after reset and advances by one, wrapping, only on such an eviction.
- R8: Invalidation code 2'b00 clears every entry.
- R9: Invalidation code 2'b01 clears only the entries whose tag equals the given tag.
- R10: Invalidation code 2'b10 clears only the entry whose page number and tag both equal the given values. Code 2'b11 changes nothing.
- R11: When invalidation and fill occur in the same cycle, the invalidation acts on the old contents and the fill is written after it. A lookup in that cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_write | input | 1 | Lookup is a write access |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No matching entry |
| lk_perm_fault | output | 1 | Entry found, write not allowed |
| lk_pfn | output | PFN_W | Frame number of the matching entry |
| lk_perm | output | PERM_W | Permissions of the matching entry |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Tag to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_perm | input | PERM_W | Permissions to install |
| inv_valid | input | 1 | Invalidation request |
| inv_kind | input | 2 | 00 all, 01 by tag, 10 one page, 11 none |
| inv_asid | input | ASID_W | Tag for tag and page invalidation |
| inv_vpn | input | VPN_W | Page number for page invalidation |

## Verification
Lookups are tried with the following patterns, and each one separates a different kind of matching fault:
- Pages present under another tag catch a match on page number alone.
- Write and read accesses to a read-only page separate a permission fault from a hit.
- A repeated fill of the same page, followed by filling every remaining slot, exposes duplicate entries.
- Filling past capacity, with a hole punched in the middle, separates first-free placement from rotating eviction.

Each of the three invalidation scopes is applied where neighbours that must survive are present. One further case puts a flush and a fill in the same cycle, which shows the order in which the two updates are applied.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      INV_ALL  = 2'b00,
      INV_ASID = 2'b01,
      INV_PAGE = 2'b10,
      INV_NONE = 2'b11
   } inv_kind_e;

   localparam int PERM_BITS = 3;
   localparam int PERM_WR   = 0;
   localparam int PERM_EX   = 1;
   localparam int PERM_USR  = 2;
endpackage

// File: rtl/xlat_first_set.sv
module xlat_first_set #(
   parameter int N     = 16,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = i[IDX_W-1:0];
      end
   end
   assign found = |vec;
endmodule

// File: rtl/xlat_slot.sv
module xlat_slot
   import xlat_pkg::*;
#(
   parameter int VPN_W       = 20,
   parameter int PFN_W       = 20,
   parameter int ASID_W      = 8,
   parameter int PERM_W      = PERM_BITS,
   parameter bit PAGE_ANY_AS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [VPN_W-1:0]  w_vpn,
   input  logic [ASID_W-1:0] w_asid,
   input  logic [PFN_W-1:0]  w_pfn,
   input  logic [PERM_W-1:0] w_perm,
   input  logic              inv_valid,
   input  logic [1:0]        inv_kind,
   input  logic [ASID_W-1:0] inv_asid,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              valid,
   output logic              lk_match,
   output logic              fill_match,
   output logic [PFN_W-1:0]  pfn,
   output logic [PERM_W-1:0] perm
);
   logic [VPN_W-1:0]  vpn_q;
   logic [ASID_W-1:0] asid_q;
   logic              page_hit_inv;
   logic              kill;

   generate
      if (PAGE_ANY_AS) begin : g_page_any
         assign page_hit_inv = (vpn_q == inv_vpn);
      end else begin : g_page_tagged
         assign page_hit_inv = (vpn_q == inv_vpn) && (asid_q == inv_asid);
      end
   endgenerate

   always_comb begin
      kill = 1'b0;
      if (inv_valid) begin
         unique case (inv_kind_e'(inv_kind))
            INV_ALL:  kill = 1'b1;
            INV_ASID: kill = (asid_q == inv_asid);
            INV_PAGE: kill = page_hit_inv;
            default:  kill = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     valid <= 1'b0;
      else if (wr_en) valid <= 1'b1;
      else if (kill)  valid <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpn_q  <= '0;
         asid_q <= '0;
         pfn    <= '0;
         perm   <= '0;
      end else if (wr_en) begin
         vpn_q  <= w_vpn;
         asid_q <= w_asid;
         pfn    <= w_pfn;
         perm   <= w_perm;
      end
   end

   assign lk_match   = valid && (vpn_q == lk_vpn) && (asid_q == lk_asid);
   assign fill_match = valid && (vpn_q == w_vpn) && (asid_q == w_asid);
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int N     = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_valid,
   input  logic [N-1:0]     valid_vec,
   input  logic [N-1:0]     dup_vec,
   output logic [IDX_W-1:0] victim_idx
);
   logic             dup_found;
   logic [IDX_W-1:0] dup_idx;
   logic             free_found;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] rr_q;

   xlat_first_set #(.N(N), .IDX_W(IDX_W)) u_dup (
      .vec(dup_vec), .found(dup_found), .idx(dup_idx));

   xlat_first_set #(.N(N), .IDX_W(IDX_W)) u_free (
      .vec(~valid_vec), .found(free_found), .idx(free_idx));

   always_comb begin
      if (dup_found)       victim_idx = dup_idx;
      else if (free_found) victim_idx = free_idx;
      else                 victim_idx = rr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rr_q <= '0;
      else if (fill_valid && !dup_found && !free_found)
         rr_q <= rr_q + 1'b1;
   end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int VPN_W       = 20,
   parameter int PFN_W       = 20,
   parameter int ASID_W      = 8,
   parameter int PERM_W      = PERM_BITS,
   parameter int ENTRIES     = 16,
   parameter bit PAGE_ANY_AS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_write,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic              lk_perm_fault,
   output logic [PFN_W-1:0]  lk_pfn,
   output logic [PERM_W-1:0] lk_perm,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic              inv_valid,
   input  logic [1:0]        inv_kind,
   input  logic [ASID_W-1:0] inv_asid,
   input  logic [VPN_W-1:0]  inv_vpn
);
   localparam int IDX_W = $clog2(ENTRIES);

   generate
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
         $error("xlat_cache: ENTRIES must be a power of two, at least 2");
      end
      if (PERM_W < PERM_BITS) begin : g_bad_perm
         $error("xlat_cache: PERM_W too narrow for the permission fields");
      end
      if (VPN_W < 1 || PFN_W < 1 || ASID_W < 1) begin : g_bad_width
         $error("xlat_cache: field widths must be positive");
      end
   endgenerate

   logic [ENTRIES-1:0] valid_vec;
   logic [ENTRIES-1:0] match_vec;
   logic [ENTRIES-1:0] dup_vec;
   logic [ENTRIES-1:0] wr_vec;
   logic [PFN_W-1:0]   pfn_arr  [ENTRIES];
   logic [PERM_W-1:0]  perm_arr [ENTRIES];
   logic [IDX_W-1:0]   victim_idx;
   logic               any_match;
   logic [IDX_W-1:0]   match_idx;
   logic               wr_ok;

   xlat_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
      .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid),
      .valid_vec(valid_vec), .dup_vec(dup_vec), .victim_idx(victim_idx));

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
         assign wr_vec[g] = fill_valid && (victim_idx == g[IDX_W-1:0]);
         xlat_slot #(
            .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W),
            .PERM_W(PERM_W), .PAGE_ANY_AS(PAGE_ANY_AS)
         ) u_slot (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_vec[g]),
            .w_vpn(fill_vpn), .w_asid(fill_asid), .w_pfn(fill_pfn),
            .w_perm(fill_perm), .inv_valid(inv_valid), .inv_kind(inv_kind),
            .inv_asid(inv_asid), .inv_vpn(inv_vpn), .lk_vpn(lk_vpn),
            .lk_asid(lk_asid), .valid(valid_vec[g]), .lk_match(match_vec[g]),
            .fill_match(dup_vec[g]), .pfn(pfn_arr[g]), .perm(perm_arr[g]));
      end
   endgenerate

   xlat_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit_sel (
      .vec(match_vec), .found(any_match), .idx(match_idx));

   assign lk_pfn  = any_match ? pfn_arr[match_idx]  : '0;
   assign lk_perm = any_match ? perm_arr[match_idx] : '0;
   assign wr_ok   = !lk_write || lk_perm[PERM_WR];

   assign lk_hit        = lk_valid && any_match && wr_ok;
   assign lk_perm_fault = lk_valid && any_match && !wr_ok;
   assign lk_miss       = lk_valid && !any_match;
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
   import xlat_pkg::*;
#(
   parameter int VPN_W       = 20,
   parameter int PFN_W       = 20,
   parameter int ASID_W      = 8,
   parameter int PERM_W      = PERM_BITS,
   parameter int ENTRIES     = 16,
   parameter bit PAGE_ANY_AS = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic [VPN_W-1:0]  lk_vpn,
   input logic [ASID_W-1:0] lk_asid,
   input logic              lk_write,
   input logic              lk_hit,
   input logic              lk_miss,
   input logic              lk_perm_fault,
   input logic [PFN_W-1:0]  lk_pfn,
   input logic [PERM_W-1:0] lk_perm,
   input logic              fill_valid,
   input logic [VPN_W-1:0]  fill_vpn,
   input logic [ASID_W-1:0] fill_asid,
   input logic [PFN_W-1:0]  fill_pfn,
   input logic [PERM_W-1:0] fill_perm,
   input logic              inv_valid,
   input logic [1:0]        inv_kind,
   input logic [ASID_W-1:0] inv_asid,
   input logic [VPN_W-1:0]  inv_vpn
);
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> $countones({lk_hit, lk_miss, lk_perm_fault}) == 1); // R3

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !lk_hit && !lk_miss && !lk_perm_fault); // R3

   AST_WRITE_NEEDS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && lk_write) |-> lk_perm[PERM_WR]); // R4

   AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(fill_valid) && lk_valid && !lk_write
       && lk_vpn == $past(fill_vpn) && lk_asid == $past(fill_asid))
      |-> (!lk_miss && lk_pfn == $past(fill_pfn))); // R5

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(inv_valid) && $past(inv_kind) == INV_ALL
       && !$past(fill_valid) && lk_valid) |-> lk_miss); // R8

   AST_RESET_EMPTY: assert property (@(posedge clk)
      (!$past(rst_n) && rst_n && !$past(fill_valid) && lk_valid) |-> lk_miss); // R1
endmodule

bind xlat_cache xlat_cache_chk #(
   .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .PERM_W(PERM_W),
   .ENTRIES(ENTRIES), .PAGE_ANY_AS(PAGE_ANY_AS)
) u_chk (.*);

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
   localparam int VW = 20, PW = 20, AW = 8, MW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lk_valid = 1'b0, lk_write = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic [AW-1:0] lk_asid = '0;
   logic lk_hit, lk_miss, lk_perm_fault;
   logic [PW-1:0] lk_pfn;
   logic [MW-1:0] lk_perm;
   logic fill_valid = 1'b0;
   logic [VW-1:0] fill_vpn = '0;
   logic [AW-1:0] fill_asid = '0;
   logic [PW-1:0] fill_pfn = '0;
   logic [MW-1:0] fill_perm = '0;
   logic inv_valid = 1'b0;
   logic [1:0] inv_kind = 2'b11;
   logic [AW-1:0] inv_asid = '0;
   logic [VW-1:0] inv_vpn = '0;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   xlat_cache uut (.*);

   task automatic do_fill(input logic [VW-1:0] v, input logic [AW-1:0] a,
                          input logic [PW-1:0] p, input logic [MW-1:0] m);
      @(negedge clk);
      fill_valid = 1'b1; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_perm = m;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic do_inv(input logic [1:0] k, input logic [AW-1:0] a,
                         input logic [VW-1:0] v);
      @(negedge clk);
      inv_valid = 1'b1; inv_kind = k; inv_asid = a; inv_vpn = v;
      @(negedge clk);
      inv_valid = 1'b0; inv_kind = 2'b11;
   endtask

   // exp: 0 miss, 1 hit, 2 permission fault
   task automatic look(input logic [VW-1:0] v, input logic [AW-1:0] a,
                       input logic wr, input int exp, input logic [PW-1:0] epfn,
                       input string req);
      logic [2:0] e, got;
      @(negedge clk);
      lk_valid = 1'b1; lk_vpn = v; lk_asid = a; lk_write = wr;
      #1;
      e   = {exp == 1, exp == 0, exp == 2};
      got = {lk_hit, lk_miss, lk_perm_fault};
      tests++;
      if (got !== e || (exp == 1 && lk_pfn !== epfn)) begin
         fails++;
         $display("FAIL %s vpn=%h asid=%h: hit/miss/fault=%b pfn=%h expected %b pfn=%h",
                  req, v, a, got, lk_pfn, e, epfn);
      end
      lk_valid = 1'b0; lk_write = 1'b0;
   endtask

   task automatic t_reset;   // R1, R3
      look(20'h00001, 8'h01, 1'b0, 0, '0, "R1");
      @(negedge clk);
      #1;
      tests++;
      if ({lk_hit, lk_miss, lk_perm_fault} !== 3'b000) begin
         fails++;
         $display("FAIL R3 idle outputs=%b expected 000", {lk_hit, lk_miss, lk_perm_fault});
      end
   endtask

   task automatic t_basic;   // R2, R4, R5
      do_fill(20'h00030, 8'h01, 20'hABCDE, 3'b000);
      look(20'h00030, 8'h01, 1'b0, 1, 20'hABCDE, "R5");
      look(20'h00030, 8'h02, 1'b0, 0, '0, "R2 tag mismatch");
      look(20'h00031, 8'h01, 1'b0, 0, '0, "R2 page mismatch");
      look(20'h00030, 8'h01, 1'b1, 2, '0, "R4 write to read-only");
      do_fill(20'h00040, 8'h01, 20'h12345, 3'b001);
      look(20'h00040, 8'h01, 1'b1, 1, 20'h12345, "R4 write allowed");
   endtask

   task automatic t_overwrite;   // R6
      do_inv(2'b00, '0, '0);
      do_fill(20'h00100, 8'h07, 20'h00111, 3'b001);
      do_fill(20'h00100, 8'h07, 20'h00222, 3'b001);
      look(20'h00100, 8'h07, 1'b0, 1, 20'h00222, "R6 new frame");
      for (int i = 1; i < 16; i++) do_fill(20'h00200 + VW'(i), 8'h07, PW'(i), 3'b001);
      look(20'h00100, 8'h07, 1'b0, 1, 20'h00222, "R6 no duplicate slot");
      look(20'h0020F, 8'h07, 1'b0, 1, 20'h0000F, "R6 last slot");
   endtask

   task automatic t_flush_all;   // R8
      do_inv(2'b00, '0, '0);
      look(20'h00100, 8'h07, 1'b0, 0, '0, "R8");
      look(20'h00205, 8'h07, 1'b0, 0, '0, "R8");
   endtask

   task automatic t_victim;   // R7
      for (int i = 0; i < 16; i++) do_fill(20'h01000 + VW'(i), 8'h02, 20'h50000 + PW'(i), 3'b001);
      do_fill(20'h01010, 8'h02, 20'h60000, 3'b001);   // evicts slot 0
      look(20'h01000, 8'h02, 1'b0, 0, '0, "R7 slot0 evicted");
      look(20'h01001, 8'h02, 1'b0, 1, 20'h50001, "R7 slot1 kept");
      do_fill(20'h01011, 8'h02, 20'h60001, 3'b001);   // evicts slot 1
      look(20'h01001, 8'h02, 1'b0, 0, '0, "R7 slot1 evicted");
      do_inv(2'b10, 8'h02, 20'h01005);
      do_fill(20'h01012, 8'h02, 20'h60002, 3'b001);   // takes free slot 5
      look(20'h01002, 8'h02, 1'b0, 1, 20'h50002, "R7 free slot preferred");
      do_fill(20'h01013, 8'h02, 20'h60003, 3'b001);   // evicts slot 2
      look(20'h01002, 8'h02, 1'b0, 0, '0, "R7 pointer advanced to 2");
      look(20'h01003, 8'h02, 1'b0, 1, 20'h50003, "R7 slot3 kept");
      look(20'h01012, 8'h02, 1'b0, 1, 20'h60002, "R7");
   endtask

   task automatic t_asid_flush;   // R9
      do_inv(2'b00, '0, '0);
      do_fill(20'h00010, 8'h03, 20'h00A10, 3'b001);
      do_fill(20'h00011, 8'h03, 20'h00A11, 3'b001);
      do_fill(20'h00010, 8'h04, 20'h00B10, 3'b001);
      do_inv(2'b01, 8'h03, 20'h00010);
      look(20'h00010, 8'h03, 1'b0, 0, '0, "R9 tag cleared");
      look(20'h00011, 8'h03, 1'b0, 0, '0, "R9 tag cleared");
      look(20'h00010, 8'h04, 1'b0, 1, 20'h00B10, "R9 other tag kept");
   endtask

   task automatic t_page_inv;   // R10
      do_fill(20'h00020, 8'h05, 20'h00C05, 3'b001);
      do_fill(20'h00020, 8'h06, 20'h00C06, 3'b001);
      do_fill(20'h00021, 8'h05, 20'h00C15, 3'b001);
      do_inv(2'b10, 8'h05, 20'h00020);
      look(20'h00020, 8'h05, 1'b0, 0, '0, "R10 page cleared");
      look(20'h00020, 8'h06, 1'b0, 1, 20'h00C06, "R10 same page other tag");
      look(20'h00021, 8'h05, 1'b0, 1, 20'h00C15, "R10 other page same tag");
      do_inv(2'b11, 8'h06, 20'h00020);
      look(20'h00020, 8'h06, 1'b0, 1, 20'h00C06, "R10 code 11 no effect");
   endtask

   task automatic t_same_cycle;   // R11
      logic [2:0] got;
      do_inv(2'b00, '0, '0);
      do_fill(20'h00300, 8'h09, 20'h00D00, 3'b001);
      @(negedge clk);
      inv_valid = 1'b1; inv_kind = 2'b00;
      fill_valid = 1'b1; fill_vpn = 20'h00301; fill_asid = 8'h09;
      fill_pfn = 20'h00D01; fill_perm = 3'b001;
      lk_valid = 1'b1; lk_vpn = 20'h00300; lk_asid = 8'h09; lk_write = 1'b0;
      #1;
      got = {lk_hit, lk_miss, lk_perm_fault};
      tests++;
      if (got !== 3'b100 || lk_pfn !== 20'h00D00) begin
         fails++;
         $display("FAIL R11 same-cycle lookup=%b pfn=%h expected 100 pfn=00d00", got, lk_pfn);
      end
      @(negedge clk);
      inv_valid = 1'b0; inv_kind = 2'b11; fill_valid = 1'b0; lk_valid = 1'b0;
      look(20'h00300, 8'h09, 1'b0, 0, '0, "R11 old entry flushed");
      look(20'h00301, 8'h09, 1'b0, 1, 20'h00D01, "R11 fill survives flush");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_overwrite();
      t_flush_all();
      t_victim();
      t_asid_flush();
      t_page_inv();
      t_same_cycle();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule